// File: doc/BRIEF.md
# Periodic Countdown Timer

This block is a 24-bit down-counter that runs periodically and is programmed through four word registers on a simple single-cycle register bus: control/status, reload value, current value and calibration. Once enabled, it decrements on every selected tick. The tick comes either from every core clock cycle or from an external one-cycle reference pulse that is synchronous to the core clock. When the count steps from one to zero, the block sets a sticky wrap flag. If interrupts are enabled, it also emits a one-cycle pending-set pulse toward an interrupt controller. On the following tick it reloads from the reload register.

Counting is held by a three-state controller. `CS_IDLE` means counting is off and the count is held. `CS_ZERO` means the counter is enabled with a zero count and reloads on the next tick. `CS_RUN` means the counter is enabled with a nonzero count and decrements on each tick. The transitions are:

- enable write: from `CS_IDLE` to `CS_ZERO` when the count is zero, or to `CS_RUN` when it is not.
- disable write: from any state to `CS_IDLE`.
- reload tick: from `CS_ZERO` to `CS_RUN`, or back to `CS_ZERO` when the reload value is zero.
- decrement tick: from `CS_RUN` to `CS_RUN`.
- wrap tick: from `CS_RUN` with a count of one to `CS_ZERO`, or to `CS_IDLE` when the reload value is zero.
- clear write: from an enabled state to `CS_ZERO`.

Reads return data in the same cycle they are presented. A read of the control/status word also clears the wrap flag at the end of that cycle.

Top module: `periodic_countdown`

## Requirements
- R1: After reset, the control/status, reload and current-value words all read 0, and `irq_set` is low.
- R2: A write to the control/status word (offset 0x0) updates only bit 0 (enable), bit 1 (interrupt enable) and bit 2 (clock select). The wrap flag at bit 16 and all other bits are unaffected by the write.
- R3: When bit 2 is 1, the counter ticks on every core clock cycle. When bit 2 is 0, it ticks only in cycles where `ref_tick` is high and holds its value otherwise.
- R4: After a reload to value N, the current value steps N, N-1, … 0 and reloads to N on the next tick, so one period is N+1 ticks.
- R5: The tick that takes the count from one to zero sets the sticky wrap flag, which reads at bit 16 of the control/status word.
- R6: On that same wrap, if bit 1 is set, `irq_set` is high for exactly one cycle. If bit 1 is clear, no pulse occurs.
- R7: A read of the control/status word returns the flag as it stood before the read, then clears it. A wrap in the same cycle as the read wins, so the flag stays set.
- R8: A write of any data to the current-value word (offset 0x8) clears the count to 0 and clears the wrap flag. The counter reloads on its next tick.
- R9: If the reload value is 0 when a wrap happens, bit 0 clears itself and counting stops.
- R10: A read of the current-value word returns 0 while bit 0 is clear.
- R11: The calibration word (offset 0xC) always reads 10000 decimal. Writes to it have no effect.
- R12: The reload (offset 0x4) and current-value words are 24 bits wide, and bits 31:24 read as zero.
- R13: Clearing bit 0 holds the count. Setting it again resumes from the held count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| ref_tick | input | 1 | External reference tick, one-cycle pulse |
| irq_set | output | 1 | One-cycle pending-set request on wrap |

## Verification
The assertions check the following on every cycle:

- `irq_set` always coincides with a set flag and never lasts two cycles.
- A wrap always leaves the flag set.
- A wrap with a zero reload always drops the enable.
- A clear write always leaves the count and the flag at zero.
- A disabled counter never moves.
- Every tick on a count above one lowers it by exactly one.

The full period length, how the count responds to reference pulses versus the core clock, the read-then-clear ordering of the flag, the masking of control writes, and the fixed calibration value are shown only by the bench's directed scenarios, which read the registers back through the bus.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

    typedef enum logic [1:0] {
        CS_IDLE = 2'd0,
        CS_ZERO = 2'd1,
        CS_RUN  = 2'd2
    } cnt_state_e;

    // word offsets on the register bus
    localparam logic [3:0] OFS_CTRL   = 4'h0;
    localparam logic [3:0] OFS_RELOAD = 4'h4;
    localparam logic [3:0] OFS_CUR    = 4'h8;
    localparam logic [3:0] OFS_CALIB  = 4'hC;

    // control/status bit positions
    localparam int BIT_EN    = 0;
    localparam int BIT_IRQEN = 1;
    localparam int BIT_SRC   = 2;
    localparam int BIT_WRAP  = 16;

endpackage

// File: rtl/pcd_tick_sel.sv
module pcd_tick_sel (
    input  logic core_sel,
    input  logic ref_tick,
    output logic tick
);

    // core clock selected: every cycle is a tick; else follow the reference pulse
    always_comb begin
        if (core_sel) begin
            tick = 1'b1;
        end else begin
            tick = ref_tick;
        end
    end

endmodule

// File: rtl/pcd_counter.sv
module pcd_counter
    import pcd_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctl_wr,
    input  logic             ctl_en_in,
    input  logic             cur_clr,
    input  logic [CNT_W-1:0] reload_val,
    output logic             enabled,
    output logic [CNT_W-1:0] count,
    output logic             wrap_ev
);

    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
            count_q <= CNT_ZERO;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    // next state, next count and wrap event
    always_comb begin
        state_d = state_q;
        count_d = count_q;
        wrap_ev = 1'b0;
        if (cur_clr) begin
            count_d = CNT_ZERO;
            if (state_q != CS_IDLE) begin
                state_d = CS_ZERO;
            end
        end else if (ctl_wr && !ctl_en_in) begin
            state_d = CS_IDLE;
        end else if (ctl_wr && ctl_en_in && (state_q == CS_IDLE)) begin
            state_d = (count_q == CNT_ZERO) ? CS_ZERO : CS_RUN;
        end else begin
            unique case (state_q)
                CS_IDLE: begin
                    state_d = CS_IDLE;
                end
                CS_ZERO: begin
                    if (tick) begin
                        count_d = reload_val;
                        state_d = (reload_val == CNT_ZERO) ? CS_ZERO : CS_RUN;
                    end
                end
                CS_RUN: begin
                    if (tick) begin
                        count_d = count_q - CNT_ONE;
                        if (count_q == CNT_ONE) begin
                            wrap_ev = 1'b1;
                            state_d = (reload_val == CNT_ZERO) ? CS_IDLE : CS_ZERO;
                        end
                    end
                end
                default: begin
                    state_d = CS_IDLE;
                end
            endcase
        end
    end

    assign enabled = (state_q != CS_IDLE);
    assign count   = count_q;

endmodule

// File: rtl/pcd_regs.sv
module pcd_regs
    import pcd_pkg::*;
#(
    parameter int                CNT_W     = 24,
    parameter int                DATA_W    = 32,
    parameter int                ADDR_W    = 4,
    parameter logic [DATA_W-1:0] CALIB_VAL = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              enabled,
    input  logic [CNT_W-1:0]  count,
    input  logic              wrap_ev,
    output logic              irq_en,
    output logic              core_sel,
    output logic [CNT_W-1:0]  reload_val,
    output logic              ctl_wr,
    output logic              ctl_en_in,
    output logic              cur_clr,
    output logic              flag,
    output logic              irq_set
);

    logic wr_ctrl, wr_reload, rd_ctrl;
    logic irq_en_q, core_sel_q, flag_q, irq_q;
    logic [CNT_W-1:0] reload_q;
    logic unused_wdata_hi;

    assign wr_ctrl   = bus_sel &&  bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_reload = bus_sel &&  bus_wr && (bus_addr == ADDR_W'(OFS_RELOAD));
    assign cur_clr   = bus_sel &&  bus_wr && (bus_addr == ADDR_W'(OFS_CUR));
    assign rd_ctrl   = bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));

    assign ctl_wr    = wr_ctrl;
    assign ctl_en_in = bus_wdata[BIT_EN];
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en_q   <= 1'b0;
            core_sel_q <= 1'b0;
            reload_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                irq_en_q   <= bus_wdata[BIT_IRQEN];
                core_sel_q <= bus_wdata[BIT_SRC];
            end
            if (wr_reload) begin
                reload_q <= bus_wdata[CNT_W-1:0];
            end
        end
    end

    // sticky wrap flag: clear write, then wrap, then read-clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (cur_clr) begin
                flag_q <= 1'b0;
            end else if (wrap_ev) begin
                flag_q <= 1'b1;
            end else if (rd_ctrl) begin
                flag_q <= 1'b0;
            end
            irq_q <= wrap_ev && irq_en_q;
        end
    end

    // read data mux
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (bus_addr)
                ADDR_W'(OFS_CTRL): begin
                    bus_rdata[BIT_EN]    = enabled;
                    bus_rdata[BIT_IRQEN] = irq_en_q;
                    bus_rdata[BIT_SRC]   = core_sel_q;
                    bus_rdata[BIT_WRAP]  = flag_q;
                end
                ADDR_W'(OFS_RELOAD): begin
                    bus_rdata[CNT_W-1:0] = reload_q;
                end
                ADDR_W'(OFS_CUR): begin
                    if (enabled) begin
                        bus_rdata[CNT_W-1:0] = count;
                    end
                end
                ADDR_W'(OFS_CALIB): begin
                    bus_rdata = CALIB_VAL;
                end
                default: begin
                    bus_rdata = '0;
                end
            endcase
        end
    end

    assign irq_en     = irq_en_q;
    assign core_sel   = core_sel_q;
    assign reload_val = reload_q;
    assign flag       = flag_q;
    assign irq_set    = irq_q;

endmodule

// File: rtl/periodic_countdown.sv
module periodic_countdown #(
    parameter int CNT_W     = 24,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int CALIB_VAL = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ref_tick,
    output logic              irq_set
);

    logic             tick_w, enabled_w, wrap_w, flag_w, irq_en_w, core_sel_w;
    logic             ctl_wr_w, ctl_en_w, cur_clr_w;
    logic [CNT_W-1:0] count_w, reload_w;

    pcd_tick_sel tick_i (
        .core_sel (core_sel_w),
        .ref_tick (ref_tick),
        .tick     (tick_w)
    );

    pcd_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_w),
        .ctl_wr     (ctl_wr_w),
        .ctl_en_in  (ctl_en_w),
        .cur_clr    (cur_clr_w),
        .reload_val (reload_w),
        .enabled    (enabled_w),
        .count      (count_w),
        .wrap_ev    (wrap_w)
    );

    pcd_regs #(
        .CNT_W     (CNT_W),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .CALIB_VAL (DATA_W'(CALIB_VAL))
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .enabled    (enabled_w),
        .count      (count_w),
        .wrap_ev    (wrap_w),
        .irq_en     (irq_en_w),
        .core_sel   (core_sel_w),
        .reload_val (reload_w),
        .ctl_wr     (ctl_wr_w),
        .ctl_en_in  (ctl_en_w),
        .cur_clr    (cur_clr_w),
        .flag       (flag_w),
        .irq_set    (irq_set)
    );

endmodule

// File: rtl/pcd_checker.sv
module pcd_checker #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic             cur_clr,
    input logic             tick,
    input logic             enabled,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] reload_val,
    input logic             wrap_ev,
    input logic             flag,
    input logic             irq_set
);

    logic any_wr;
    assign any_wr = bus_sel && bus_wr;

    // R6
    irq_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |-> flag);

    // R6
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |=> !irq_set);

    // R5
    wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_ev |=> flag);

    // R9
    zero_reload_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_ev && (reload_val == '0)) |=> !enabled);

    // R8
    clear_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_clr |=> ((count == '0) && !flag));

    // R13
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enabled && !any_wr) |=> $stable(count));

    // R4
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && tick && !any_wr && (count > CNT_W'(1)))
        |=> (count == $past(count) - CNT_W'(1)));

endmodule

bind periodic_countdown pcd_checker #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .cur_clr    (cur_clr_w),
    .tick       (tick_w),
    .enabled    (enabled_w),
    .count      (count_w),
    .reload_val (reload_w),
    .wrap_ev    (wrap_w),
    .flag       (flag_w),
    .irq_set    (irq_set)
);

// File: tb/periodic_countdown_tb_top.sv
module periodic_countdown_tb_top;

    localparam logic [3:0] A_CTRL  = 4'h0;
    localparam logic [3:0] A_RLD   = 4'h4;
    localparam logic [3:0] A_CUR   = 4'h8;
    localparam logic [3:0] A_CAL   = 4'hC;
    localparam logic [31:0] FLAG_M = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        ref_tick = 1'b0;
    logic        irq_set;

    int n_chk = 0;
    int n_bad = 0;
    int irq_cnt = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    periodic_countdown dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ref_tick  (ref_tick),
        .irq_set   (irq_set)
    );

    always @(negedge clk) begin
        if (irq_set) irq_cnt++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // all bus tasks start and end at a falling edge
    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic pulse_ref();
        ref_tick = 1'b1;
        @(negedge clk);
        ref_tick = 1'b0;
    endtask

    task automatic read_expect(input string req, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        check(req, d, exp);
    endtask

    task automatic t_reset();
        check("R1 irq_set", {31'h0, irq_set}, 32'h0);
        read_expect("R1 ctrl", A_CTRL, 32'h0);
        read_expect("R1 reload", A_RLD, 32'h0);
        read_expect("R1 current", A_CUR, 32'h0);
    endtask

    task automatic t_core_period();
        int base;
        logic [31:0] exp_seq [7] = '{32'd0, 32'd4, 32'd3, 32'd2, 32'd1, 32'd0, 32'd4};
        base = irq_cnt;
        bus_write(A_RLD, 32'd4);
        bus_write(A_CUR, 32'h0);
        bus_write(A_CTRL, 32'h7);
        for (int i = 0; i < 7; i++) begin
            read_expect("R4 core sequence", A_CUR, exp_seq[i]);
        end
        read_expect("R5 flag after wrap", A_CTRL, FLAG_M | 32'h7);
        bus_write(A_CTRL, 32'h0);
        check("R6 one irq pulse", irq_cnt - base, 32'd1);
    endtask

    task automatic t_ref_ticks();
        int base;
        base = irq_cnt;
        bus_write(A_RLD, 32'd2);
        bus_write(A_CUR, 32'h0);
        bus_write(A_CTRL, 32'h1);
        repeat (5) @(negedge clk);
        read_expect("R3 no tick no move", A_CUR, 32'd0);
        pulse_ref();
        read_expect("R3 reload on ref", A_CUR, 32'd2);
        repeat (3) @(negedge clk);
        read_expect("R3 hold between ref", A_CUR, 32'd2);
        pulse_ref();
        pulse_ref();
        read_expect("R4 ref reaches zero", A_CUR, 32'd0);
        pulse_ref();
        read_expect("R4 ref reload", A_CUR, 32'd2);
        check("R6 no irq when disabled", irq_cnt - base, 32'd0);
    endtask

    task automatic t_clear_write();
        bus_write(A_CUR, 32'h00AB_CDEF);
        read_expect("R8 count cleared", A_CUR, 32'd0);
        read_expect("R8 flag cleared", A_CTRL, 32'h1);
        pulse_ref();
        read_expect("R8 reload next tick", A_CUR, 32'd2);
    endtask

    task automatic t_pause();
        pulse_ref();
        bus_write(A_CTRL, 32'h0);
        read_expect("R10 current reads zero off", A_CUR, 32'd0);
        pulse_ref();
        pulse_ref();
        bus_write(A_CTRL, 32'h1);
        read_expect("R13 resume held count", A_CUR, 32'd1);
        pulse_ref();
    endtask

    task automatic t_zero_reload();
        pulse_ref();
        read_expect("R9 count reloaded", A_CUR, 32'd2);
        bus_write(A_RLD, 32'd0);
        pulse_ref();
        pulse_ref();
        bus_write(A_CTRL, 32'hFFFE_FFFA);
        read_expect("R2 R9 masked write, stopped", A_CTRL, FLAG_M | 32'h2);
        read_expect("R7 flag cleared by read", A_CTRL, 32'h2);
        pulse_ref();
        read_expect("R10 stopped reads zero", A_CUR, 32'd0);
    endtask

    task automatic t_wide_and_calib();
        bus_write(A_RLD, 32'hFFFF_FFFF);
        read_expect("R12 reload upper zero", A_RLD, 32'h00FF_FFFF);
        bus_write(A_CUR, 32'h0);
        bus_write(A_CTRL, 32'h5);
        read_expect("R12 first read", A_CUR, 32'd0);
        read_expect("R12 current upper zero", A_CUR, 32'h00FF_FFFF);
        read_expect("R3 core step", A_CUR, 32'h00FF_FFFE);
        bus_write(A_CTRL, 32'h0);
        read_expect("R11 calibration", A_CAL, 32'd10000);
        bus_write(A_CAL, 32'h0);
        read_expect("R11 calibration after write", A_CAL, 32'd10000);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_core_period();
        t_ref_ticks();
        t_clear_write();
        t_pause();
        t_zero_reload();
        t_wide_and_calib();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule